// File: doc/BRIEF.md
# Machine-Mode Trap and Privilege Controller

This block holds the privilege level (machine or user) of a small RISC-style core and runs trap entry and trap return. Each cycle the core presents at most a handful of events: an environment call, a return-from-trap, a synchronous page fault of a given kind, and a level-sensitive timer-pending line from an external comparator. The core also presents the address of the instruction currently at the commit point. The controller arbitrates these events and updates its trap state. It then issues a one-cycle redirect to the fixed trap vector on entry, or to the saved exception PC on return.

The controller keeps three machine registers and lets software read and write them: the exception PC, a status word, and the cause word. The status word holds the global interrupt enable at bit 3, the stacked enable at bit 7 and the stacked privilege at bits 12:11. Software writes the timer compare value elsewhere and only then sets the global enable. Faults save the faulting instruction's own address, so the access runs again after return. Environment calls save their own address too, and the handler advances it.

Top module: `trap_priv_ctrl`

## Requirements
- R1: After a synchronous reset the privilege output is machine (`2'b11`) and `redir_valid` is 0. A later read of the exception PC, status or cause returns zero.
- R2: An environment call moves the privilege to machine and saves `insn_pc` as the exception PC. It writes cause code 8 when taken from user mode and 11 when taken from machine mode, with bit 31 clear, and redirects to `TVEC`.
- R3: A return taken in machine mode sets the privilege to the stacked privilege field (00 user, 11 machine) and redirects to the saved exception PC. The enable is reloaded from the stacked enable, the stacked enable becomes 1, and the stacked privilege becomes user (00).
- R4: A fault saves `insn_pc` itself as the exception PC (not `insn_pc`+4). It writes cause 12, 13 or 15 for `fault_kind` 00 (fetch), 01 (load) or 10 (store), and `fault_kind` 11 is treated as a store.
- R5: Every trap entry copies the current privilege into the stacked privilege field and the enable into the stacked enable, and clears the enable.
- R6: A pending timer is taken only while the enable (status bit 3) is 1. When taken it writes cause `0x8000_0007` and saves `insn_pc`. While the enable is 0 it causes no redirect and no state change.
- R7: When events coincide, a fault outranks an environment call, which outranks a return, which outranks the timer interrupt.
- R8: `redir_valid` is high for exactly the one cycle after an accepted event and low otherwise.
- R9: A return presented in user mode is ignored: no redirect, and the privilege stays user.
- R10: With `csr_we`, selector 0 writes the exception PC and selector 1 writes the enable, stacked enable and stacked privilege. A stacked-privilege value other than 11 is stored as 00. Writes to the cause (selector 2) are dropped, and an event accepted in the same cycle overrides the write.
- R11: `csr_rdata` is registered: it shows the register chosen by `csr_sel` (0 exception PC, 1 status, 2 cause, 3 zero) as it stood before the clock edge that samples the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_ecall | input | 1 | Environment call at the commit point |
| ev_mret | input | 1 | Return-from-trap at the commit point |
| ev_fault | input | 1 | Page fault on the instruction at the commit point |
| fault_kind | input | 2 | 00 fetch, 01 load, 10/11 store |
| timer_pending | input | 1 | Timer compare has matched |
| insn_pc | input | XLEN | Address of the instruction at the commit point |
| csr_we | input | 1 | Software write strobe |
| csr_sel | input | 2 | Register select for read and write |
| csr_wdata | input | XLEN | Software write data |
| priv_mode | output | 2 | Current privilege, 00 user, 11 machine |
| redir_valid | output | 1 | One-cycle fetch redirect strobe |
| redir_pc | output | XLEN | Redirect target |
| csr_rdata | output | XLEN | Registered read data |

## Verification
The bench first takes a trap from user mode and returns with a stacked privilege of 11, checking that the privilege follows the stacked field rather than being forced to one level. A controller that hard-wired the return level would come back to the wrong privilege. It then raises a pending timer with the enable clear and again right after a trap has cleared it; a design without the gate would vector into the handler repeatedly. Faults are checked for the unadvanced exception PC, so a design that stored PC+4 would skip the retried access. Coincident fault, call and timer events check the priority order. A status write that carries 01 in the privilege field and a write on the same cycle as a trap check the write rules; a wrong design would keep an illegal level or a stale exception PC.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    SEL_EPC    = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CAUSE  = 2'd2,
    SEL_NONE   = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TRAP = 2'd1,
    ACT_RET  = 2'd2
  } act_e;

  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_ECALL_U  = 4'd8;
  localparam logic [CODE_W-1:0] CODE_ECALL_M  = 4'd11;
  localparam logic [CODE_W-1:0] CODE_PF_FETCH = 4'd12;
  localparam logic [CODE_W-1:0] CODE_PF_LOAD  = 4'd13;
  localparam logic [CODE_W-1:0] CODE_PF_STORE = 4'd15;
  localparam logic [CODE_W-1:0] CODE_TIMER    = 4'd7;

  localparam int ST_IE_BIT   = 3;
  localparam int ST_PIE_BIT  = 7;
  localparam int ST_PPRV_LO  = 11;
  localparam int ST_PPRV_HI  = 12;
endpackage

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter
  import trap_pkg::*;
(
  input  logic              ev_fault,
  input  logic [1:0]        fault_kind,
  input  logic              ev_ecall,
  input  logic              ev_mret,
  input  logic              timer_pending,
  input  priv_e             cur_priv,
  input  logic              irq_en,
  output act_e              act,
  output logic              is_irq,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    act    = ACT_NONE;
    is_irq = 1'b0;
    code   = '0;
    if (ev_fault) begin
      act = ACT_TRAP;
      unique case (fault_kind)
        2'b00:   code = CODE_PF_FETCH;
        2'b01:   code = CODE_PF_LOAD;
        default: code = CODE_PF_STORE;
      endcase
    end else if (ev_ecall) begin
      act  = ACT_TRAP;
      code = (cur_priv == PRIV_M) ? CODE_ECALL_M : CODE_ECALL_U;
    end else if (ev_mret && cur_priv == PRIV_M) begin
      act = ACT_RET;
    end else if (timer_pending && irq_en) begin
      act    = ACT_TRAP;
      is_irq = 1'b1;
      code   = CODE_TIMER;
    end
  end
endmodule

// File: rtl/trap_state.sv
`timescale 1ns/1ps
module trap_state
  import trap_pkg::*;
#(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] TVEC = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  act_e              act,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   insn_pc,
  input  logic              csr_we,
  input  csr_sel_e          csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output priv_e             priv_q,
  output logic              ie_q,
  output logic              pie_q,
  output priv_e             pprv_q,
  output logic [XLEN-1:0]   epc_q,
  output logic              cause_irq_q,
  output logic [CODE_W-1:0] cause_code_q,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      priv_q       <= PRIV_M;
      ie_q         <= 1'b0;
      pie_q        <= 1'b0;
      pprv_q       <= PRIV_U;
      epc_q        <= '0;
      cause_irq_q  <= 1'b0;
      cause_code_q <= '0;
      redir_valid  <= 1'b0;
      redir_pc     <= '0;
    end else begin
      redir_valid <= 1'b0;
      unique case (act)
        ACT_TRAP: begin
          priv_q       <= PRIV_M;
          pprv_q       <= priv_q;
          pie_q        <= ie_q;
          ie_q         <= 1'b0;
          epc_q        <= insn_pc;
          cause_irq_q  <= is_irq;
          cause_code_q <= code;
          redir_valid  <= 1'b1;
          redir_pc     <= TVEC;
        end
        ACT_RET: begin
          priv_q      <= pprv_q;
          ie_q        <= pie_q;
          pie_q       <= 1'b1;
          pprv_q      <= PRIV_U;
          redir_valid <= 1'b1;
          redir_pc    <= epc_q;
        end
        default: begin
          if (csr_we) begin
            unique case (csr_sel)
              SEL_EPC: epc_q <= csr_wdata;
              SEL_STATUS: begin
                ie_q   <= csr_wdata[ST_IE_BIT];
                pie_q  <= csr_wdata[ST_PIE_BIT];
                pprv_q <= (csr_wdata[ST_PPRV_HI:ST_PPRV_LO] == 2'b11) ? PRIV_M : PRIV_U;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/trap_csr_rd.sv
`timescale 1ns/1ps
module trap_csr_rd
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  csr_sel_e          sel,
  input  logic [XLEN-1:0]   epc,
  input  logic              ie,
  input  logic              pie,
  input  priv_e             pprv,
  input  logic              cause_irq,
  input  logic [CODE_W-1:0] cause_code,
  output logic [XLEN-1:0]   rdata
);
  logic [XLEN-1:0] status_w;
  logic [XLEN-1:0] cause_w;

  always_comb begin
    status_w                        = '0;
    status_w[ST_IE_BIT]             = ie;
    status_w[ST_PIE_BIT]            = pie;
    status_w[ST_PPRV_HI:ST_PPRV_LO] = pprv;
    cause_w                         = '0;
    cause_w[XLEN-1]                 = cause_irq;
    cause_w[CODE_W-1:0]             = cause_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (sel)
        SEL_EPC:    rdata <= epc;
        SEL_STATUS: rdata <= status_w;
        SEL_CAUSE:  rdata <= cause_w;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/trap_priv_ctrl.sv
`timescale 1ns/1ps
module trap_priv_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] TVEC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_ecall,
  input  logic            ev_mret,
  input  logic            ev_fault,
  input  logic [1:0]      fault_kind,
  input  logic            timer_pending,
  input  logic [XLEN-1:0] insn_pc,
  input  logic            csr_we,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [1:0]      priv_mode,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] csr_rdata
);
  act_e              act;
  logic              is_irq;
  logic [CODE_W-1:0] code;
  priv_e             priv_q;
  logic              ie_q;
  logic              pie_q;
  priv_e             pprv_q;
  logic [XLEN-1:0]   epc_q;
  logic              cause_irq_q;
  logic [CODE_W-1:0] cause_code_q;
  csr_sel_e          sel_e;

  assign sel_e     = csr_sel_e'(csr_sel);
  assign priv_mode = priv_q;

  trap_arbiter u_arb (
    .ev_fault      (ev_fault),
    .fault_kind    (fault_kind),
    .ev_ecall      (ev_ecall),
    .ev_mret       (ev_mret),
    .timer_pending (timer_pending),
    .cur_priv      (priv_q),
    .irq_en        (ie_q),
    .act           (act),
    .is_irq        (is_irq),
    .code          (code)
  );

  trap_state #(.XLEN(XLEN), .TVEC(TVEC)) u_state (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .is_irq       (is_irq),
    .code         (code),
    .insn_pc      (insn_pc),
    .csr_we       (csr_we),
    .csr_sel      (sel_e),
    .csr_wdata    (csr_wdata),
    .priv_q       (priv_q),
    .ie_q         (ie_q),
    .pie_q        (pie_q),
    .pprv_q       (pprv_q),
    .epc_q        (epc_q),
    .cause_irq_q  (cause_irq_q),
    .cause_code_q (cause_code_q),
    .redir_valid  (redir_valid),
    .redir_pc     (redir_pc)
  );

  trap_csr_rd #(.XLEN(XLEN)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel_e),
    .epc        (epc_q),
    .ie         (ie_q),
    .pie        (pie_q),
    .pprv       (pprv_q),
    .cause_irq  (cause_irq_q),
    .cause_code (cause_code_q),
    .rdata      (csr_rdata)
  );
endmodule

// File: rtl/trap_priv_ctrl_chk.sv
`timescale 1ns/1ps
module trap_priv_ctrl_chk #(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] TVEC = 32'h0000_0100
) (
  input logic            clk,
  input logic            rst,
  input logic            ev_ecall,
  input logic            ev_mret,
  input logic            ev_fault,
  input logic            timer_pending,
  input logic [XLEN-1:0] insn_pc,
  input logic [1:0]      priv_mode,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_pc,
  input logic            ie_q,
  input logic [1:0]      pprv_q,
  input logic [XLEN-1:0] epc_q
);
  AST_ECALL_TO_MACHINE: assert property (@(posedge clk) disable iff (rst)
    (ev_ecall && !ev_fault) |=> (priv_mode == 2'b11 && redir_valid && redir_pc == TVEC)); // R2

  AST_FAULT_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
    ev_fault |=> (epc_q == $past(insn_pc))); // R4

  AST_RET_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (ev_mret && !ev_fault && !ev_ecall && priv_mode == 2'b11)
      |=> (priv_mode == $past(pprv_q) && redir_pc == $past(epc_q))); // R3

  AST_TIMER_GATED: assert property (@(posedge clk) disable iff (rst)
    (timer_pending && !ie_q && !ev_fault && !ev_ecall && !ev_mret) |=> !redir_valid); // R6

  AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
    (ev_fault || ev_ecall) |=> !ie_q); // R5

  AST_USER_RET_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ev_mret && !ev_fault && !ev_ecall && !timer_pending && priv_mode == 2'b00)
      |=> (!redir_valid && priv_mode == 2'b00)); // R9

  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (priv_mode == 2'b00 || priv_mode == 2'b11)); // R3
endmodule

bind trap_priv_ctrl trap_priv_ctrl_chk #(.XLEN(XLEN), .TVEC(TVEC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_ecall      (ev_ecall),
  .ev_mret       (ev_mret),
  .ev_fault      (ev_fault),
  .timer_pending (timer_pending),
  .insn_pc       (insn_pc),
  .priv_mode     (priv_mode),
  .redir_valid   (redir_valid),
  .redir_pc      (redir_pc),
  .ie_q          (ie_q),
  .pprv_q        (pprv_q),
  .epc_q         (epc_q)
);

// File: tb/trap_priv_ctrl_test.sv
`timescale 1ns/1ps
module trap_priv_ctrl_test;
  localparam int          XLEN = 32;
  localparam logic [31:0] TVEC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_ecall = 0, ev_mret = 0, ev_fault = 0, timer_pending = 0, csr_we = 0;
  logic [1:0]  fault_kind = 0, csr_sel = 0;
  logic [31:0] insn_pc = 0, csr_wdata = 0;
  logic [1:0]  priv_mode;
  logic        redir_valid;
  logic [31:0] redir_pc, csr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trap_priv_ctrl #(.XLEN(XLEN), .TVEC(TVEC)) uut (
    .clk(clk), .rst(rst), .ev_ecall(ev_ecall), .ev_mret(ev_mret), .ev_fault(ev_fault),
    .fault_kind(fault_kind), .timer_pending(timer_pending), .insn_pc(insn_pc),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .priv_mode(priv_mode),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .csr_rdata(csr_rdata)
  );

  typedef struct {
    logic        rv;
    logic [31:0] rpc;
    logic [1:0]  priv;
    logic        chk_csr;
    logic [31:0] csr_val;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  // reference state held by the bench, built from the requirements
  logic [1:0]  m_priv = 2'b11, m_pprv = 2'b00;
  logic        m_ie = 0, m_pie = 0, m_cirq = 0;
  logic [3:0]  m_code = 0;
  logic [31:0] m_epc = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ec, input logic mr, input logic fl, input logic [1:0] fk,
                      input logic tp, input logic [31:0] pc, input logic we,
                      input logic [1:0] sel, input logic [31:0] wd,
                      input logic chk, input string req);
    exp_t e;
    logic [31:0] st, ca;
    @(negedge clk);
    ev_ecall = ec; ev_mret = mr; ev_fault = fl; fault_kind = fk; timer_pending = tp;
    insn_pc = pc; csr_we = we; csr_sel = sel; csr_wdata = wd;
    st = 32'h0; st[3] = m_ie; st[7] = m_pie; st[12:11] = m_pprv;
    ca = {m_cirq, 27'h0, m_code};
    e.chk_csr = chk; e.req = req;
    e.csr_val = (sel == 2'd0) ? m_epc : (sel == 2'd1) ? st : (sel == 2'd2) ? ca : 32'h0;
    e.rv = 1'b0; e.rpc = 32'h0;
    if (fl || ec || (tp && m_ie && !(mr && m_priv == 2'b11))) begin
      // trap entry
      m_cirq = !fl && !ec;
      if (fl) m_code = (fk == 2'b00) ? 4'd12 : (fk == 2'b01) ? 4'd13 : 4'd15;
      else if (ec) m_code = (m_priv == 2'b11) ? 4'd11 : 4'd8;
      else m_code = 4'd7;
      m_pprv = m_priv; m_pie = m_ie; m_ie = 1'b0; m_priv = 2'b11; m_epc = pc;
      e.rv = 1'b1; e.rpc = TVEC;
    end else if (mr && m_priv == 2'b11) begin
      m_priv = m_pprv; m_ie = m_pie; m_pie = 1'b1; m_pprv = 2'b00;
      e.rv = 1'b1; e.rpc = m_epc;
    end else if (we) begin
      if (sel == 2'd0) m_epc = wd;
      else if (sel == 2'd1) begin
        m_ie = wd[3]; m_pie = wd[7]; m_pprv = (wd[12:11] == 2'b11) ? 2'b11 : 2'b00;
      end
    end
    e.priv = m_priv;
    exp_q.push_back(e);
  endtask

  task automatic rd(input logic [1:0] sel, input string req);
    step(0, 0, 0, 2'b00, 0, 32'h0, 0, sel, 32'h0, 1'b1, req);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] wd, input string req);
    step(0, 0, 0, 2'b00, 0, 32'h0, 1, sel, wd, 1'b0, req);
  endtask

  // monitor: one expectation per cycle, sampled 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, "priv_mode", {30'h0, priv_mode}, {30'h0, e.priv});
        check(e.req, "redir_valid", {31'h0, redir_valid}, {31'h0, e.rv});
        if (e.rv) check(e.req, "redir_pc", redir_pc, e.rpc);
        if (e.chk_csr) check(e.req, "csr_rdata", csr_rdata, e.csr_val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "priv after reset", {30'h0, priv_mode}, 32'h3);
    check("R1", "redir after reset", {31'h0, redir_valid}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R11");
    // timer pending with enable clear
    step(0, 0, 0, 2'b00, 1, 32'h0000_0040, 0, 2'd1, 0, 1'b1, "R6");
    rd(2'd2, "R6");
    // program exception PC, return to user
    wr(2'd0, 32'h0000_1000, "R10");
    rd(2'd0, "R10");
    step(0, 1, 0, 2'b00, 0, 32'h0, 0, 2'd1, 0, 1'b0, "R3");
    rd(2'd1, "R3"); rd(2'd1, "R8");
    // return in user mode is ignored
    step(0, 1, 0, 2'b00, 0, 32'h0, 0, 2'd0, 0, 1'b0, "R9");
    rd(2'd0, "R9");
    // environment call from user
    step(1, 0, 0, 2'b00, 0, 32'h0000_1004, 0, 2'd0, 0, 1'b0, "R2");
    rd(2'd2, "R2"); rd(2'd0, "R2"); rd(2'd1, "R5");
    // status write, then call from machine
    wr(2'd1, 32'h0000_1808, "R10");
    rd(2'd1, "R10");
    step(1, 0, 0, 2'b00, 0, 32'h0000_2000, 0, 2'd0, 0, 1'b0, "R2");
    rd(2'd2, "R2"); rd(2'd1, "R5");
    // return with stacked machine privilege
    wr(2'd0, 32'h0000_3000, "R10");
    step(0, 1, 0, 2'b00, 0, 32'h0, 0, 2'd0, 0, 1'b0, "R3");
    rd(2'd1, "R3");
    // illegal stacked privilege is stored as user
    wr(2'd1, 32'h0000_0888, "R10");
    rd(2'd1, "R10");
    wr(2'd0, 32'h0000_4000, "R10");
    step(0, 1, 0, 2'b00, 0, 32'h0, 0, 2'd0, 0, 1'b0, "R3");
    // timer taken in user mode with enable set
    step(0, 0, 0, 2'b00, 1, 32'h0000_4010, 0, 2'd0, 0, 1'b0, "R6");
    step(0, 0, 0, 2'b00, 1, 32'h0000_4014, 0, 2'd2, 0, 1'b0, "R6");
    rd(2'd2, "R6"); rd(2'd0, "R6"); rd(2'd1, "R5");
    // faults of each kind
    step(0, 0, 1, 2'b01, 0, 32'h0000_4020, 0, 2'd0, 0, 1'b0, "R4");
    rd(2'd0, "R4"); rd(2'd2, "R4");
    step(0, 0, 1, 2'b10, 0, 32'h0000_4024, 0, 2'd0, 0, 1'b0, "R4");
    rd(2'd2, "R4");
    step(0, 0, 1, 2'b11, 0, 32'h0000_4028, 0, 2'd0, 0, 1'b0, "R4");
    rd(2'd2, "R4");
    // priority: fault over call over timer
    wr(2'd1, 32'h0000_0008, "R7");
    step(1, 1, 1, 2'b00, 1, 32'h0000_5000, 0, 2'd0, 0, 1'b0, "R7");
    rd(2'd2, "R7"); rd(2'd0, "R7");
    wr(2'd1, 32'h0000_0008, "R7");
    step(1, 1, 0, 2'b00, 1, 32'h0000_5004, 0, 2'd0, 0, 1'b0, "R7");
    rd(2'd2, "R7");
    // return outranks timer
    wr(2'd1, 32'h0000_0088, "R7");
    wr(2'd0, 32'h0000_5100, "R7");
    step(0, 1, 0, 2'b00, 1, 32'h0000_5008, 0, 2'd0, 0, 1'b0, "R7");
    // timer now taken in user
    step(0, 0, 0, 2'b00, 1, 32'h0000_5104, 0, 2'd0, 0, 1'b0, "R6");
    rd(2'd2, "R6");
    // write on same cycle as a trap is overridden; cause writes dropped
    step(1, 0, 0, 2'b00, 0, 32'h0000_6000, 1, 2'd0, 32'hDEAD_BEEC, 1'b0, "R10");
    rd(2'd0, "R10");
    wr(2'd2, 32'h0000_0003, "R10");
    rd(2'd2, "R10");
    rd(2'd3, "R11");
    step(0, 0, 0, 2'b00, 0, 32'h0, 0, 2'd0, 0, 1'b0, "R8");
    step(0, 0, 0, 2'b00, 0, 32'h0, 0, 2'd0, 0, 1'b0, "R8");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule